// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block manages coherence for one cache in a bus-based multiprocessor. It keeps a tag and a three-valued block state (Invalid, Shared, Exclusive) for every set of a small direct-mapped cache. Processor requests are resolved locally when they hit. When a request needs the bus, the block raises a read-miss, write-miss or write-back operation on a shared snoop bus with a valid/ready handshake. Operations that other caches place on the bus arrive at a snoop port. They downgrade or invalidate the local copy, and they raise a write-back strobe when the local copy is dirty.

Tags and states are held twice. One copy serves the processor lookup and one serves the snoop lookup, so a snoop never waits for the processor port. Every update writes both copies. The bus is split-transaction: each set carries a pending flag from the moment its read or write operation is accepted until a response for that set arrives. No new bus operation starts on a set whose flag is set. Write misses are posted, so the processor sees completion as soon as the bus takes the operation. Read misses complete when their response returns. When a snoop and a processor request address the same set in one cycle, the snoop is applied first and the processor request is judged again in the next cycle.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every set is Invalid, no set is pending, and busReqValid, cpuDone and snoopWbValid are low.
- R2: A processor read that misses raises busReqValid with busReqOp 0 (read miss) and the request address. cpuDone stays low in that cycle. The block becomes Shared, and cpuDone pulses in the cycle a busRespValid carrying the same address is seen.
- R3: A processor write that misses raises busReqOp 1 (write miss) with the request address. cpuDone is high in the cycle the bus accepts it, and the block becomes Exclusive. A write that hits an Exclusive block completes in the same cycle with no bus operation.
- R4: A processor write that hits a Shared block raises busReqOp 1 with the request address, completes on acceptance, and leaves the block Exclusive.
- R5: A processor miss on a set whose resident block is Exclusive under another tag first raises busReqOp 2 (write-back) with the victim address {old tag, index}. The set then becomes Invalid, and the read or write miss for the new address follows in the next cycle.
- R6: A snooped write miss (snoopOp 1) that matches a Shared block makes it Invalid without a write-back, so the next processor read to it misses.
- R7: A snooped read miss (snoopOp 0) that matches an Exclusive block pulses snoopWbValid with snoopWbAddr equal to the snooped address in the same cycle. The block becomes Shared, so a later processor write to it issues an upgrade write miss.
- R8: A snooped write miss that matches an Exclusive block pulses snoopWbValid with the snooped address and makes the block Invalid.
- R9: A snoop with a non-matching tag, a snoop to an Invalid set, or a snoop with snoopOp 2 raises no write-back and leaves the local block unchanged.
- R10: While a set is pending, no bus operation is raised for a processor request to that set. The request goes out in the cycle after a busRespValid whose address index selects that set. Requests to other sets proceed meanwhile.
- R11: When snoopValid and a processor request address the same index in one cycle, busReqValid and cpuDone are held low in that cycle. The request is then evaluated against the state left by the snoop.
- R12: A processor read that hits a Shared or Exclusive block pulses cpuDone in the same cycle, raises no bus operation and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present; held with its fields until cpuDone |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Block address, low IDX_W bits select the set |
| cpuDone | output | 1 | Processor request completes this cycle |
| busReqValid | output | 1 | Bus operation offered |
| busReqReady | input | 1 | Bus accepts the offered operation |
| busReqOp | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| busReqAddr | output | ADDR_W | Block address of the bus operation |
| busRespValid | input | 1 | Response for a split transaction |
| busRespAddr | input | ADDR_W | Address the response belongs to |
| snoopValid | input | 1 | Operation of another cache seen on the bus |
| snoopOp | input | 2 | Snooped operation, same encoding as busReqOp |
| snoopAddr | input | ADDR_W | Snooped block address |
| snoopWbValid | output | 1 | Local dirty block must be written back |
| snoopWbAddr | output | ADDR_W | Address of that write-back |

## Verification
A snoop and a processor request can land on the same set in one cycle. The snoop may change the very state the processor lookup is reading. The bench provokes this by raising a processor read hit on a Shared block together with a snooped write miss to that block. It expects no completion and no bus operation in that cycle, then a fresh read miss in the next cycle. The directed pending test pairs a response with a waiting request to the same set, and the random phase mixes snoops and processor traffic over a few sets and tags to reach every state transition.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    BLK_INV = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blkState_t;

  typedef enum logic [1:0] {
    OP_RDMISS = 2'd0,
    OP_WRMISS = 2'd1,
    OP_WRBACK = 2'd2
  } busOp_t;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_WAIT = 1'b1
  } ctlState_t;

  // Strobes from the control FSM to the tag/state datapath
  typedef struct packed {
    logic installEn;
    logic installExcl;
    logic upgradeEn;
    logic evictEn;
    logic pendSet;
  } ctlStrobe_t;

endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  ctlStrobe_t        strobe,
  input  logic              snoopValid,
  input  logic [1:0]        snoopOp,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              respValid,
  input  logic [IDX_W-1:0]  respIdx,
  output logic              cpuTagHit,
  output blkState_t         cpuState,
  output logic [ADDR_W-1:0] victimAddr,
  output logic              pendHere,
  output logic              snoopConflict,
  output logic              snoopWbValid,
  output logic [ADDR_W-1:0] snoopWbAddr
);

  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  blkState_t        cpuStArr  [SETS];
  logic [TAG_W-1:0] cpuTagArr [SETS];
  blkState_t        snpStArr  [SETS];
  logic [TAG_W-1:0] snpTagArr [SETS];
  logic [SETS-1:0]  pendVec;

  logic [IDX_W-1:0] cIdx, sIdx;
  logic [TAG_W-1:0] cTag, sTag;
  blkState_t        snpCur, snpNext;
  logic             snpHit, snpUpd;

  assign cIdx = cpuAddr[IDX_W-1:0];
  assign cTag = cpuAddr[ADDR_W-1:IDX_W];
  assign sIdx = snoopAddr[IDX_W-1:0];
  assign sTag = snoopAddr[ADDR_W-1:IDX_W];

  // Processor-side lookup
  assign cpuState   = cpuStArr[cIdx];
  assign cpuTagHit  = (cpuTagArr[cIdx] == cTag);
  assign victimAddr = {cpuTagArr[cIdx], cIdx};
  assign pendHere   = pendVec[cIdx];

  // Snoop-side lookup on its own copy
  assign snpCur        = snpStArr[sIdx];
  assign snpHit        = snoopValid && (snpTagArr[sIdx] == sTag) && (snpCur != BLK_INV);
  assign snoopConflict = snoopValid && (sIdx == cIdx);

  always_comb begin
    snpNext = snpCur;
    snpUpd  = 1'b0;
    if (snpHit) begin
      if (snoopOp == OP_RDMISS && snpCur == BLK_EXC) begin
        snpNext = BLK_SHR;
        snpUpd  = 1'b1;
      end else if (snoopOp == OP_WRMISS) begin
        snpNext = BLK_INV;
        snpUpd  = 1'b1;
      end
    end
  end

  assign snoopWbValid = snpHit && (snpCur == BLK_EXC) &&
                        (snoopOp == OP_RDMISS || snoopOp == OP_WRMISS);
  assign snoopWbAddr  = snoopAddr;

  // Both copies receive every update; snoop wins on its own set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        cpuStArr[s]  <= BLK_INV;
        snpStArr[s]  <= BLK_INV;
        cpuTagArr[s] <= '0;
        snpTagArr[s] <= '0;
      end
      pendVec <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (snpUpd && sIdx == IDX_W'(s)) begin
          cpuStArr[s] <= snpNext;
          snpStArr[s] <= snpNext;
        end else if (cIdx == IDX_W'(s)) begin
          if (strobe.evictEn) begin
            cpuStArr[s] <= BLK_INV;
            snpStArr[s] <= BLK_INV;
          end else if (strobe.upgradeEn) begin
            cpuStArr[s] <= BLK_EXC;
            snpStArr[s] <= BLK_EXC;
          end else if (strobe.installEn) begin
            cpuStArr[s]  <= strobe.installExcl ? BLK_EXC : BLK_SHR;
            snpStArr[s]  <= strobe.installExcl ? BLK_EXC : BLK_SHR;
            cpuTagArr[s] <= cTag;
            snpTagArr[s] <= cTag;
          end
        end
        if (strobe.pendSet && cIdx == IDX_W'(s)) begin
          pendVec[s] <= 1'b1;
        end else if (respValid && respIdx == IDX_W'(s)) begin
          pendVec[s] <= 1'b0;
        end
      end
    end
  end

  AST_UPGRADE_FROM_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.upgradeEn |-> (cpuState == BLK_SHR && cpuTagHit)); // R4

  AST_SNOOP_WB_CLEARS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    snoopWbValid |=> (snpStArr[$past(sIdx)] != BLK_EXC)); // R7

endmodule

// File: rtl/coh_control.sv
module coh_control
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic              cpuTagHit,
  input  blkState_t         cpuState,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              pendHere,
  input  logic              snoopConflict,
  input  logic              busReqReady,
  input  logic              busRespValid,
  input  logic [ADDR_W-1:0] busRespAddr,
  output logic              cpuDone,
  output logic              busReqValid,
  output logic [1:0]        busReqOp,
  output logic [ADDR_W-1:0] busReqAddr,
  output ctlStrobe_t        strobe
);

  ctlState_t st, stNext;
  logic      hit, victimDirty;

  assign hit         = cpuTagHit && (cpuState != BLK_INV);
  assign victimDirty = !cpuTagHit && (cpuState == BLK_EXC);

  always_comb begin
    stNext      = st;
    cpuDone     = 1'b0;
    busReqValid = 1'b0;
    busReqOp    = OP_RDMISS;
    busReqAddr  = cpuReqAddr;
    strobe      = '0;
    case (st)
      CTL_IDLE: begin
        if (cpuReqValid && !snoopConflict) begin
          if (hit && (!cpuReqWrite || cpuState == BLK_EXC)) begin
            cpuDone = 1'b1;
          end else if (!pendHere) begin
            busReqValid = 1'b1;
            if (victimDirty) begin
              busReqOp       = OP_WRBACK;
              busReqAddr     = victimAddr;
              strobe.evictEn = busReqReady;
            end else begin
              busReqOp = cpuReqWrite ? OP_WRMISS : OP_RDMISS;
              if (busReqReady) begin
                strobe.pendSet = 1'b1;
                if (hit) begin
                  strobe.upgradeEn = 1'b1;
                end else begin
                  strobe.installEn   = 1'b1;
                  strobe.installExcl = cpuReqWrite;
                end
                if (cpuReqWrite) cpuDone = 1'b1;
                else             stNext  = CTL_WAIT;
              end
            end
          end
        end
      end
      CTL_WAIT: begin
        if (busRespValid && busRespAddr == cpuReqAddr) begin
          cpuDone = 1'b1;
          stNext  = CTL_IDLE;
        end
      end
      default: stNext = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= CTL_IDLE;
    else       st <= stNext;
  end

  AST_NO_OP_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> !pendHere); // R10

  AST_SNOOP_GOES_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (snoopConflict && st == CTL_IDLE) |-> (!busReqValid && !cpuDone)); // R11

  AST_WRITEBACK_BEFORE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqOp != OP_WRBACK) |-> !(cpuState == BLK_EXC && !cpuTagHit)); // R5

endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  output logic              cpuDone,
  output logic              busReqValid,
  input  logic              busReqReady,
  output logic [1:0]        busReqOp,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              busRespValid,
  input  logic [ADDR_W-1:0] busRespAddr,
  input  logic              snoopValid,
  input  logic [1:0]        snoopOp,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopWbValid,
  output logic [ADDR_W-1:0] snoopWbAddr
);

  ctlStrobe_t        strobe;
  logic              cpuTagHit, pendHere, snoopConflict;
  blkState_t         cpuState;
  logic [ADDR_W-1:0] victimAddr;

  coh_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .cpuAddr      (cpuReqAddr),
    .strobe       (strobe),
    .snoopValid   (snoopValid),
    .snoopOp      (snoopOp),
    .snoopAddr    (snoopAddr),
    .respValid    (busRespValid),
    .respIdx      (busRespAddr[IDX_W-1:0]),
    .cpuTagHit    (cpuTagHit),
    .cpuState     (cpuState),
    .victimAddr   (victimAddr),
    .pendHere     (pendHere),
    .snoopConflict(snoopConflict),
    .snoopWbValid (snoopWbValid),
    .snoopWbAddr  (snoopWbAddr)
  );

  coh_control #(.ADDR_W(ADDR_W)) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReqValid  (cpuReqValid),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqAddr   (cpuReqAddr),
    .cpuTagHit    (cpuTagHit),
    .cpuState     (cpuState),
    .victimAddr   (victimAddr),
    .pendHere     (pendHere),
    .snoopConflict(snoopConflict),
    .busReqReady  (busReqReady),
    .busRespValid (busRespValid),
    .busRespAddr  (busRespAddr),
    .cpuDone      (cpuDone),
    .busReqValid  (busReqValid),
    .busReqOp     (busReqOp),
    .busReqAddr   (busReqAddr),
    .strobe       (strobe)
  );

  AST_SNOOP_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    snoopWbValid |-> (snoopValid && snoopOp != 2'd2)); // R9

endmodule

// File: tb/test_snoop_coherence_ctrl.sv
module test_snoop_coherence_ctrl;

  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int SETS   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic              cpuDone;
  logic              busReqValid, busReqReady = 1'b0;
  logic [1:0]        busReqOp;
  logic [ADDR_W-1:0] busReqAddr;
  logic              busRespValid = 1'b0;
  logic [ADDR_W-1:0] busRespAddr = '0;
  logic              snoopValid = 1'b0;
  logic [1:0]        snoopOp = '0;
  logic [ADDR_W-1:0] snoopAddr = '0;
  logic              snoopWbValid;
  logic [ADDR_W-1:0] snoopWbAddr;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // Model: 0 Invalid, 1 Shared, 2 Exclusive
  int                     mSt  [SETS];
  logic [ADDR_W-IDX_W-1:0] mTag [SETS];

  always #5 clk = ~clk;

  snoop_coherence_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_snoop_coherence_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr),
    .cpuDone(cpuDone),
    .busReqValid(busReqValid), .busReqReady(busReqReady), .busReqOp(busReqOp),
    .busReqAddr(busReqAddr),
    .busRespValid(busRespValid), .busRespAddr(busRespAddr),
    .snoopValid(snoopValid), .snoopOp(snoopOp), .snoopAddr(snoopAddr),
    .snoopWbValid(snoopWbValid), .snoopWbAddr(snoopWbAddr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isHit(logic [ADDR_W-1:0] a);
    return (mTag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W]) && (mSt[a[IDX_W-1:0]] != 0);
  endfunction

  // Processor request with an always-ready bus; posted writes get their response
  // in the next cycle unless holdResp is set.
  task automatic doCpu(bit wr, logic [ADDR_W-1:0] a, bit holdResp = 1'b0);
    int idx = int'(a[IDX_W-1:0]);
    bit hit = isHit(a);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqAddr = a; busReqReady = 1'b1;
    #1;
    if (hit && (!wr || mSt[idx] == 2)) begin
      check(wr ? "R3 write hit done" : "R12 read hit done", cpuDone, 1);
      check(wr ? "R3 write hit no bus" : "R12 read hit no bus", busReqValid, 0);
    end else begin
      if (!hit && mSt[idx] == 2) begin
        check("R5 writeback valid", busReqValid, 1);
        check("R5 writeback op", busReqOp, 2);
        check("R5 victim addr", busReqAddr, {mTag[idx], a[IDX_W-1:0]});
        mSt[idx] = 0;
        @(negedge clk);
        #1;
      end
      check(hit ? "R4 upgrade valid" : (wr ? "R3 miss valid" : "R2 miss valid"), busReqValid, 1);
      check(hit ? "R4 upgrade op" : (wr ? "R3 miss op" : "R2 miss op"), busReqOp, wr ? 1 : 0);
      check(wr ? "R3 miss addr" : "R2 miss addr", busReqAddr, a);
      check(wr ? "R3 posted done" : "R2 no early done", cpuDone, wr ? 1 : 0);
      if (!hit) mTag[idx] = a[ADDR_W-1:IDX_W];
      mSt[idx] = wr ? 2 : 1;
      @(negedge clk);
      if (wr) begin
        cpuReqValid = 1'b0;
        if (!holdResp) begin busRespValid = 1'b1; busRespAddr = a; end
      end else begin
        busRespValid = 1'b1; busRespAddr = a;
        #1;
        check("R2 done on response", cpuDone, 1);
      end
    end
    @(negedge clk);
    cpuReqValid = 1'b0; busRespValid = 1'b0; busReqReady = 1'b0;
  endtask

  task automatic doSnoop(logic [1:0] op, logic [ADDR_W-1:0] a);
    int idx = int'(a[IDX_W-1:0]);
    bit match = isHit(a);
    bit expWb = match && mSt[idx] == 2 && op != 2'd2;
    string req;
    if (!match || op == 2'd2) req = "R9 snoop no effect";
    else if (mSt[idx] == 1) req = "R6 snoop on shared";
    else req = (op == 2'd0) ? "R7 snoop read on excl" : "R8 snoop write on excl";
    @(negedge clk);
    snoopValid = 1'b1; snoopOp = op; snoopAddr = a;
    #1;
    check(req, snoopWbValid, expWb);
    if (expWb) check(req, snoopWbAddr, a);
    if (match && op == 2'd1) mSt[idx] = 0;
    else if (match && op == 2'd0 && mSt[idx] == 2) mSt[idx] = 1;
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx);
    return {9'(tag), 3'(idx)};
  endfunction

  initial begin
    for (int s = 0; s < SETS; s++) begin mSt[s] = 0; mTag[s] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset busReqValid", busReqValid, 0);
    check("R1 reset cpuDone", cpuDone, 0);
    check("R1 reset snoopWbValid", snoopWbValid, 0);

    // R1/R2: tag 0 must still miss after reset; then R12 read hit
    doCpu(1'b0, mk(0, 1));
    doCpu(1'b0, mk(0, 1));
    // R4 upgrade, R3 write hit on Exclusive
    doCpu(1'b1, mk(0, 1));
    doCpu(1'b1, mk(0, 1));
    // R7 then upgrade again
    doSnoop(2'd0, mk(0, 1));
    doCpu(1'b1, mk(0, 1));
    // R5 replace Exclusive
    doCpu(1'b1, mk(5, 1));
    // R9: other tag, snoop write-back op; state still Exclusive (write hit)
    doSnoop(2'd1, mk(6, 1));
    doSnoop(2'd2, mk(5, 1));
    doCpu(1'b1, mk(5, 1));
    // R8 then read misses
    doSnoop(2'd1, mk(5, 1));
    doCpu(1'b0, mk(5, 1));
    // R6: Shared block invalidated, next read misses
    doSnoop(2'd1, mk(5, 1));
    doCpu(1'b0, mk(5, 1));
    doSnoop(2'd0, mk(7, 6));

    // R10 pending set blocks its own set, other sets proceed
    doCpu(1'b1, mk(3, 2), 1'b1);
    doCpu(1'b0, mk(3, 3));
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b1; cpuReqAddr = mk(4, 2); busReqReady = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R10 blocked while pending", busReqValid, 0);
      check("R10 no done while pending", cpuDone, 0);
      @(negedge clk);
    end
    busRespValid = 1'b1; busRespAddr = mk(3, 2);
    #1;
    check("R10 blocked in response cycle", busReqValid, 0);
    @(negedge clk);
    busRespValid = 1'b0; cpuReqValid = 1'b0; busReqReady = 1'b0;
    doCpu(1'b1, mk(4, 2));

    // R11 snoop and processor on the same set in one cycle
    doCpu(1'b0, mk(2, 4));
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b0; cpuReqAddr = mk(2, 4); busReqReady = 1'b1;
    snoopValid = 1'b1; snoopOp = 2'd1; snoopAddr = mk(2, 4);
    #1;
    check("R11 no done on conflict", cpuDone, 0);
    check("R11 no bus op on conflict", busReqValid, 0);
    mSt[4] = 0;
    @(negedge clk);
    snoopValid = 1'b0;
    #1;
    check("R11 re-evaluated as miss", busReqValid, 1);
    check("R11 re-evaluated op", busReqOp, 0);
    mSt[4] = 1;
    @(negedge clk);
    busRespValid = 1'b1; busRespAddr = mk(2, 4);
    #1;
    check("R11 done after response", cpuDone, 1);
    @(negedge clk);
    cpuReqValid = 1'b0; busRespValid = 1'b0; busReqReady = 1'b0;

    // Random mix over four sets and three tags
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 3);
      logic [ADDR_W-1:0] a = mk(int'($urandom % 3), int'($urandom % 4));
      if (r == 0) doSnoop(2'($urandom % 3), a);
      else        doCpu(1'($urandom % 2), a);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule